// File: doc/BRIEF.md
# Serial Memory Slave Command Core

This block is the command front end of a byte-addressed memory that is reached over a single-lane serial peripheral bus. It samples the bus pins into a faster system clock, finds the serial clock edges there, and decodes one 8-bit command per chip-select window. The commands set or clear a write-enable latch, read or write a status byte, read or write the memory array with a running address, read the array with eight ignored clocks after the address, and return a fixed 4-byte identifier. The array is an internal register array whose depth comes from the `ADDR_W` parameter.

The status byte holds the write-enable latch, two region-protect bits, two latency bits and a protect-enable bit. Writes to the array are refused when the latch is clear or when the target address falls inside the region the protect bits select. Writes to the status byte are refused when the latch is clear, or when protect-enable is set and the write-protect pin is low. The bus may idle its clock low or high. Data is sampled on the rising edge and driven on the falling edge in both cases.

Top module: `spiMemSlave`

## Requirements
- R1: Command 06h sets the write-enable latch and command 04h clears it. The latch is status bit 1.
- R2: After a read (03h), fast read (0Bh) or write (02h) command, a 24-bit address follows MSB first. Only its low `ADDR_W` bits are used. Each further data byte steps the address by one, and the address wraps from all-ones to zero.
- R3: `so` changes only on falling serial clock edges. `soOe` is 0 whenever `csN` has been high for three system clocks, and it is 1 while `csN` stays low.
- R4: The write-enable latch clears when `csN` rises after a recognised status-write (01h) or write (02h) command. This holds even if the command was cut short.
- R5: Status layout: bit 7 protect-enable, bits 5:4 latency, bits 3:2 region protect, bit 1 latch. Bits 6 and 0 always read 0. A status write ignores its bits 6, 1 and 0. The status byte reads 00h after reset.
- R6: With the latch clear, no array byte changes. With the latch set, region protect 00 guards nothing, 01 guards addresses whose top two bits are 11, 10 guards addresses whose top bit is 1, and 11 guards every address.
- R7: A status write takes effect only when the latch is set and either protect-enable is 0 or `wpN` is 1.
- R8: Command 9Fh returns 04h, 7Fh, 29h, 85h in that order. After the last bit, `so` holds that bit until `csN` rises.
- R9: Command 05h keeps returning the current status byte while clocks continue. A `csN` rise before the eighth command bit abandons the command.
- R10: Fast read (0Bh) skips eight clocks after the address and then returns data from that address.
- R11: Commands decode the same whether the serial clock idles low or high at the `csN` fall.
- R12: An array byte is written only after all 8 of its bits have arrived. A partial byte at the `csN` rise is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| csN | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Write-protect pin; low locks the status byte when protect-enable is set |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for `so`; 0 means high-impedance |

## Verification
The hardest situation to reach is the status lock, because it needs three conditions at once. Protect-enable must first be written as 1 with `wpN` high. The latch must then be set again, since every status write clears it. Finally a status write must arrive with `wpN` low. The stimulus table walks that exact order and reads the status byte back after each step. The partial-byte and abandoned-command cases need a `csN` rise partway through a byte, so a directed test drives bit-level clocks and then checks memory and the latch through ordinary reads.

// File: rtl/spiMemPkg.sv
`timescale 1ns/1ps
package spiMemPkg;

  localparam logic [7:0] OP_SETWE  = 8'h06;
  localparam logic [7:0] OP_CLRWE  = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_FASTRD = 8'h0B;

  typedef enum logic [3:0] {
    PH_OP, PH_ADDR, PH_DUMMY, PH_RDDATA, PH_WRDATA,
    PH_SRDATA, PH_SRWR, PH_ID, PH_IDEND, PH_IGNORE
  } phase_e;

  typedef enum logic [2:0] {
    TX_NONE, TX_STATUS, TX_ID, TX_MEMNEW, TX_MEMCUR, TX_MEMNEXT
  } txSrc_e;

  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic       csLow;
    logic       csRise;
    logic       txShift;
    logic       setWel;
    logic       clrWel;
    logic       armWel;
    logic       wrStatus;
    logic       wrMem;
    logic       addrShift;
    logic       addrLatch;
    logic       addrInc;
    txSrc_e     txSrc;
    logic [1:0] idSel;
    logic [7:0] rxByte;
    logic       wpHigh;
    logic       idEnd;
  } strb_t;

  function automatic logic [7:0] idByte(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h04;
      2'd1:    return 8'h7F;
      2'd2:    return 8'h29;
      default: return 8'h85;
    endcase
  endfunction

endpackage

// File: rtl/spiSync.sv
`timescale 1ns/1ps
module spiSync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= RST_VAL;
      else       stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spiMemCtrl.sv
`timescale 1ns/1ps
module spiMemCtrl
  import spiMemPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sckS,
  input  logic  csNS,
  input  logic  siS,
  input  logic  wpNS,
  output strb_t strb
);
  logic       sckP, csNP;
  logic [2:0] bitCnt;
  logic [7:0] rxSh;
  logic [1:0] byteIdx, byteIdxNx;
  logic       isWr, isWrNx, isFast, isFastNx, seenRise;
  phase_e     phase, phaseNx;

  logic csLow, csRise, rise, fall, byteDone;
  logic [7:0] rxByte;

  assign csLow    = ~csNS;
  assign csRise   = csNS & ~csNP;
  assign rise     = sckS & ~sckP & csLow;
  assign fall     = ~sckS & sckP & csLow;
  assign byteDone = rise && (bitCnt == 3'd7);
  assign rxByte   = {rxSh[6:0], siS};

  always_comb begin
    strb         = '0;
    strb.txSrc   = TX_NONE;
    strb.csLow   = csLow;
    strb.csRise  = csRise;
    strb.wpHigh  = wpNS;
    strb.rxByte  = rxByte;
    strb.idEnd   = (phase == PH_IDEND);
    // a leading fall before any rise (clock idling high) is not a data edge
    strb.txShift = fall && seenRise && (phase inside {PH_SRDATA, PH_RDDATA, PH_ID});
    phaseNx   = phase;
    byteIdxNx = byteIdx;
    isWrNx    = isWr;
    isFastNx  = isFast;
    if (byteDone) begin
      case (phase)
        PH_OP: begin
          case (rxByte)
            OP_SETWE:  begin strb.setWel = 1'b1; phaseNx = PH_IGNORE; end
            OP_CLRWE:  begin strb.clrWel = 1'b1; phaseNx = PH_IGNORE; end
            OP_RDSTAT: begin strb.txSrc = TX_STATUS; phaseNx = PH_SRDATA; end
            OP_WRSTAT: begin strb.armWel = 1'b1; phaseNx = PH_SRWR; end
            OP_READ:   begin phaseNx = PH_ADDR; byteIdxNx = 2'd0; isWrNx = 1'b0; isFastNx = 1'b0; end
            OP_FASTRD: begin phaseNx = PH_ADDR; byteIdxNx = 2'd0; isWrNx = 1'b0; isFastNx = 1'b1; end
            OP_WRITE:  begin
              strb.armWel = 1'b1; phaseNx = PH_ADDR; byteIdxNx = 2'd0;
              isWrNx = 1'b1; isFastNx = 1'b0;
            end
            OP_RDID:   begin
              strb.txSrc = TX_ID; strb.idSel = 2'd0; byteIdxNx = 2'd1; phaseNx = PH_ID;
            end
            default:   phaseNx = PH_IGNORE;
          endcase
        end
        PH_ADDR: begin
          strb.addrShift = 1'b1;
          if (byteIdx == 2'd2) begin
            strb.addrLatch = 1'b1;
            if (isWr)        phaseNx = PH_WRDATA;
            else if (isFast) phaseNx = PH_DUMMY;
            else begin
              strb.txSrc = TX_MEMNEW;
              phaseNx    = PH_RDDATA;
            end
          end else begin
            byteIdxNx = byteIdx + 2'd1;
          end
        end
        PH_DUMMY:  begin strb.txSrc = TX_MEMCUR; phaseNx = PH_RDDATA; end
        PH_RDDATA: begin strb.addrInc = 1'b1; strb.txSrc = TX_MEMNEXT; end
        PH_WRDATA: begin strb.wrMem = 1'b1; strb.addrInc = 1'b1; end
        PH_SRDATA: strb.txSrc = TX_STATUS;
        PH_SRWR:   begin strb.wrStatus = 1'b1; phaseNx = PH_IGNORE; end
        PH_ID: begin
          if (byteIdx == 2'd0) phaseNx = PH_IDEND;
          else begin
            strb.txSrc = TX_ID;
            strb.idSel = byteIdx;
            byteIdxNx  = byteIdx + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckP <= 1'b0; csNP <= 1'b1;
      bitCnt <= '0; rxSh <= '0; byteIdx <= '0;
      isWr <= 1'b0; isFast <= 1'b0; seenRise <= 1'b0;
      phase <= PH_OP;
    end else begin
      sckP <= sckS;
      csNP <= csNS;
      if (!csLow) begin
        bitCnt <= '0; byteIdx <= '0; seenRise <= 1'b0;
        isWr <= 1'b0; isFast <= 1'b0;
        phase <= PH_OP;
      end else begin
        if (rise) begin
          bitCnt   <= bitCnt + 3'd1;
          rxSh     <= rxByte;
          seenRise <= 1'b1;
        end
        phase   <= phaseNx;
        byteIdx <= byteIdxNx;
        isWr    <= isWrNx;
        isFast  <= isFastNx;
      end
    end
  end

  // R9: a chip-select rise always returns the decoder to the command stage
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (phase == PH_OP) && (bitCnt == 3'd0));

endmodule

// File: rtl/spiMemDpath.sv
`timescale 1ns/1ps
module spiMemDpath
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  strb_t strb,
  output logic  so,
  output logic  soOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              wel, wpen, welArm, soQ, soOeQ;
  logic [1:0]        lc, bp;
  logic [15:0]       addrSh;
  logic [ADDR_W-1:0] addrQ, newAddr, addrNext;
  logic [7:0]        txSh, txLoad, statusByte;
  logic [7:0]        mem [DEPTH];
  logic [23:0]       fullAddr;
  logic              unusedAddrHi;
  logic [1:0]        top2;
  logic              inProt, memOk, statusOk;

  assign fullAddr     = {addrSh, strb.rxByte};
  assign newAddr      = fullAddr[ADDR_W-1:0];
  assign unusedAddrHi = ^fullAddr[23:ADDR_W];
  assign addrNext     = addrQ + 1'b1;
  assign statusByte   = {wpen, 1'b0, lc, bp, wel, 1'b0};
  assign top2         = addrQ[ADDR_W-1 -: 2];

  always_comb begin
    case (bp)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (top2 == 2'b11);
      2'b10:   inProt = top2[1];
      default: inProt = 1'b1;
    endcase
  end

  assign memOk    = wel && !inProt;
  assign statusOk = wel && (!wpen || strb.wpHigh);

  always_comb begin
    case (strb.txSrc)
      TX_STATUS:  txLoad = statusByte;
      TX_ID:      txLoad = idByte(strb.idSel);
      TX_MEMNEW:  txLoad = mem[newAddr];
      TX_MEMCUR:  txLoad = mem[addrQ];
      TX_MEMNEXT: txLoad = mem[addrNext];
      default:    txLoad = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0; welArm <= 1'b0;
      wpen <= 1'b0; lc <= '0; bp <= '0;
      addrSh <= '0; addrQ <= '0;
      txSh <= '0; soQ <= 1'b0; soOeQ <= 1'b0;
    end else begin
      soOeQ <= strb.csLow;
      if (strb.csRise && welArm) wel <= 1'b0;
      else if (strb.setWel)      wel <= 1'b1;
      else if (strb.clrWel)      wel <= 1'b0;
      if (strb.csRise)      welArm <= 1'b0;
      else if (strb.armWel) welArm <= 1'b1;
      if (strb.wrStatus && statusOk) begin
        wpen <= strb.rxByte[7];
        lc   <= strb.rxByte[5:4];
        bp   <= strb.rxByte[3:2];
      end
      if (strb.addrShift) addrSh <= {addrSh[7:0], strb.rxByte};
      if (strb.addrLatch)    addrQ <= newAddr;
      else if (strb.addrInc) addrQ <= addrNext;
      if (strb.txSrc != TX_NONE) txSh <= txLoad;
      else if (strb.txShift) begin
        soQ  <= txSh[7];
        txSh <= {txSh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrMem && memOk) mem[addrQ] <= strb.rxByte;
  end

  assign so   = soQ;
  assign soOe = soOeQ;

  // R4: an armed latch is gone one clock after the chip-select rise
  assert_wel_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.csRise && welArm) |=> !wel);
  // R7: a locked status write leaves the stored fields untouched
  assert_sr_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && wpen && !strb.wpHigh) |=> $stable({wpen, lc, bp}));
  // R2: the running address wraps to zero
  assert_addr_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrInc && (addrQ == {ADDR_W{1'b1}})) |=> (addrQ == '0));
  // R8: once the identifier is exhausted the output bit stays put
  assert_id_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.idEnd && $past(strb.idEnd)) |-> $stable(soQ));

endmodule

// File: rtl/spiMemSlave.sv
`timescale 1ns/1ps
module spiMemSlave
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  input  logic wpN,
  output logic so,
  output logic soOe
);
  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_RST = 4'b1010; // {wpN, si, csN, sck}

  logic [PIN_W-1:0] pinS;
  strb_t strb;

  spiSync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rstN(rstN), .d({wpN, si, csN, sck}), .q(pinS)
  );

  spiMemCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sckS(pinS[0]), .csNS(pinS[1]), .siS(pinS[2]), .wpNS(pinS[3]),
    .strb(strb)
  );

  spiMemDpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .so(so), .soOe(soOe)
  );

  // R3: a deselected device does not drive its output
  assert_so_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soOe);

endmodule

// File: tb/spiMemSlave_bench.sv
`timescale 1ns/1ps
module spiMemSlave_bench;
  localparam int HALF = 60;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, si = 1'b0, wpN = 1'b1;
  logic so, soOe;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spiMemSlave u_spiMemSlave (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .wpN(wpN),
    .so(so), .soOe(soOe)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        hasAddr;
    logic [23:0] addr;
    logic [2:0]  nBytes;
    logic [31:0] din;
    logic [31:0] mask;
    logic [31:0] exp;
    logic        wp;
    logic        mode3;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS[NV] = '{
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h00000000,1'b1,1'b0,4'd5},       // R5 reset status
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h02000000,1'b1,1'b0,4'd1},       // R1 latch set
    '{8'h02,1'b1,24'h000010,3'd2,32'h5A3C0000,32'h0,32'h0,1'b1,1'b0,4'd2},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h00000000,1'b1,1'b0,4'd4},       // R4 cleared after write
    '{8'h02,1'b1,24'h000010,3'd1,32'hFF000000,32'h0,32'h0,1'b1,1'b0,4'd6},
    '{8'h03,1'b1,24'h000010,3'd2,32'h0,32'hFFFF0000,32'h5A3C0000,1'b1,1'b0,4'd6},  // R6 no latch, no write
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h02,1'b1,24'hFFFFFF,3'd2,32'h11220000,32'h0,32'h0,1'b1,1'b0,4'd2},
    '{8'h03,1'b1,24'hE000FF,3'd2,32'h0,32'hFFFF0000,32'h11220000,1'b1,1'b0,4'd2},  // R2 wrap, high bits ignored
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h02,1'b1,24'h0000C0,3'd1,32'h55000000,32'h0,32'h0,1'b1,1'b0,4'd6},
    '{8'h0B,1'b1,24'h000011,3'd2,32'h0,32'h00FF0000,32'h003C0000,1'b1,1'b0,4'd10}, // R10 fast read
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h01,1'b0,24'h0,3'd1,32'hFF000000,32'h0,32'h0,1'b1,1'b0,4'd5},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'hBC000000,1'b1,1'b0,4'd5},       // R5 ignored bits
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h02,1'b1,24'h000010,3'd1,32'h77000000,32'h0,32'h0,1'b1,1'b0,4'd6},
    '{8'h03,1'b1,24'h000010,3'd1,32'h0,32'hFF000000,32'h5A000000,1'b1,1'b0,4'd6},  // R6 all guarded
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h01,1'b0,24'h0,3'd1,32'h00000000,32'h0,32'h0,1'b0,1'b0,4'd7},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'hBC000000,1'b1,1'b0,4'd7},       // R7 locked
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h01,1'b0,24'h0,3'd1,32'h84000000,32'h0,32'h0,1'b1,1'b0,4'd7},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h84000000,1'b1,1'b0,4'd7},       // R7 unlocked by pin
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h02,1'b1,24'h0000BF,3'd2,32'h99880000,32'h0,32'h0,1'b1,1'b0,4'd6},
    '{8'h03,1'b1,24'h0000BF,3'd2,32'h0,32'hFFFF0000,32'h99550000,1'b1,1'b0,4'd6},  // R6 upper quarter
    '{8'h9F,1'b0,24'h0,3'd4,32'h0,32'hFFFFFFFF,32'h047F2985,1'b1,1'b0,4'd8},       // R8 identifier
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h84000000,1'b1,1'b1,4'd11},      // R11 idle-high clock
    '{8'h03,1'b1,24'h000010,3'd1,32'h0,32'hFF000000,32'h5A000000,1'b1,1'b1,4'd11}, // R11
    '{8'h06,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h04,1'b0,24'h0,3'd0,32'h0,32'h0,32'h0,1'b1,1'b0,4'd1},
    '{8'h05,1'b0,24'h0,3'd1,32'h0,32'hFF000000,32'h84000000,1'b1,1'b0,4'd1},       // R1 latch cleared
    '{8'h05,1'b0,24'h0,3'd3,32'h0,32'hFFFFFF00,32'h84848400,1'b1,1'b0,4'd9}        // R9 repeated status
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic oPre, output logic oPost);
    sck = 1'b0; si = b;
    #HALF; oPre = so;
    sck = 1'b1;
    #(HALF-5); oPost = so;
    #5;
  endtask

  task automatic sendByte(input logic [7:0] d, output logic [7:0] q);
    logic a, b;
    for (int i = 7; i >= 0; i--) begin
      bitx(d[i], a, b);
      q[i] = a;
    end
  endtask

  task automatic csStart(input logic mode3);
    sck = mode3; #40; csN = 1'b0; #80;
  endtask

  task automatic csEnd(input logic mode3);
    if (!mode3) sck = 1'b0;
    #HALF; csN = 1'b1; #150;
  endtask

  task automatic runVec(input vec_t t);
    logic [31:0] got;
    logic [7:0] q;
    wpN = t.wp;
    csStart(t.mode3);
    sendByte(t.op, q);
    if (t.hasAddr) for (int i = 0; i < 3; i++) sendByte(t.addr[23-8*i -: 8], q);
    got = '0;
    for (int i = 0; i < int'(t.nBytes); i++) begin
      sendByte(t.din[31-8*i -: 8], q);
      got[31-8*i -: 8] = q;
    end
    csEnd(t.mode3);
    wpN = 1'b1;
    if (t.mask != 0) check($sformatf("R%0d", t.req), got & t.mask, t.exp & t.mask);
  endtask

  task automatic readOne(input logic [7:0] op, input logic hasAddr, input logic [23:0] addr,
                         output logic [7:0] q);
    logic [7:0] d;
    csStart(1'b0);
    sendByte(op, d);
    if (hasAddr) for (int i = 0; i < 3; i++) sendByte(addr[23-8*i -: 8], d);
    sendByte(8'h00, q);
    csEnd(1'b0);
  endtask

  initial begin
    logic [7:0] q;
    logic a, b, steady, held;
    #100; rstN = 1'b1; #100;
    check("R3 reset output enable", {31'd0, soOe}, 32'd0);

    for (int v = 0; v < NV; v++) runVec(VECS[v]);

    // R3: enable follows chip select
    csStart(1'b0);
    check("R3 enable while selected", {31'd0, soOe}, 32'd1);
    csEnd(1'b0);
    check("R3 enable after deselect", {31'd0, soOe}, 32'd0);

    // R8 hold of last bit, R3 output steady across rising edges
    csStart(1'b0);
    sendByte(8'h9F, q);
    steady = 1'b1;
    for (int i = 0; i < 32; i++) begin
      bitx(1'b0, a, b);
      if (a !== b) steady = 1'b0;
    end
    held = 1'b1;
    for (int i = 0; i < 12; i++) begin
      bitx(1'b0, a, b);
      if (a !== 1'b1 || b !== 1'b1) held = 1'b0;
    end
    csEnd(1'b0);
    check("R3 output steady over rising edge", {31'd0, steady}, 32'd1);
    check("R8 last bit held", {31'd0, held}, 32'd1);

    // R9: command cut after seven bits is abandoned
    csStart(1'b0);
    for (int i = 7; i >= 1; i--) bitx(OP_BITS[i], a, b);
    csEnd(1'b0);
    readOne(8'h05, 1'b0, 24'h0, q);
    check("R9 abandoned latch set", {24'd0, q}, 32'h84);

    // R12 partial byte dropped, R4 latch cleared after cut write
    csStart(1'b0); sendByte(8'h06, q); csEnd(1'b0);
    csStart(1'b0);
    sendByte(8'h02, q);
    sendByte(8'h00, q); sendByte(8'h00, q); sendByte(8'h11, q);
    for (int i = 0; i < 4; i++) bitx(1'b1, a, b);
    csEnd(1'b0);
    readOne(8'h03, 1'b1, 24'h000011, q);
    check("R12 partial byte", {24'd0, q}, 32'h3C);
    readOne(8'h05, 1'b0, 24'h0, q);
    check("R4 latch after cut write", {24'd0, q}, 32'h84);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  localparam logic [7:0] OP_BITS = 8'h06;

  initial begin
    #1_500_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog all requirements got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule